// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is a small two-way set-associative data cache. It sits between a processor request port that issues one word access at a time and a slower main-memory port that moves one word per request/acknowledge handshake. Every line holds a valid flag, a dirty flag, a read-only flag and a tag. Every set holds one bit that names the way used most recently. Hits are served from the cache. A miss first writes a dirty victim back to memory, then loads the whole block. A write that misses loads its block the same way and then writes into the cache. Main memory is updated only when a dirty line is evicted.

Lines are marked read-only through a memory-side attribute that arrives with the refill data. A write aimed at such a line is refused and flagged. Two invalidation inputs let the rest of the system drop the whole cache contents or one addressed line, for example after another agent has changed that region of memory. Dirty data in a dropped line is discarded.

The configuration is held in the package: a 10-bit word address, 32-bit words, 4 sets and 4 words per block.

Top module: `dcache2w`

## Requirements
- R1: A word address is split with the word offset in bits [1:0], the set index in bits [3:2] and the tag in bits [9:4]. A way hits when its valid flag is set and its stored tag equals the address tag, and a read hit returns that way's word at the offset.
- R2: `req_ready` is high only when no request is in progress, so only one request is ever outstanding. A hit raises `resp_valid` in the cycle right after the acceptance edge, two cycles in total. During a miss `req_ready` stays low until the response has been given.
- R3: A write hit stores the word in the cache only and marks the line dirty. No memory request is issued for it, and `resp_err` is 0.
- R4: A read miss loads all 4 words of the block from memory, with the block base as the address of the first word. It then returns the requested word. `mem_addr` and `mem_we` stay stable while a memory request waits for `mem_ack`.
- R5: When the chosen victim is valid and dirty, all 4 of its words are written to memory at the victim's own address before the first refill read is issued.
- R6: A write miss loads the block and then performs the write in the cache. A later read of that word hits and returns the written value.
- R7: The victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way that the set's recency bit does not name. Every hit, including a refused write, makes the hit way the most recent.
- R8: `mem_rdonly` sampled with the last refill word sets the line's read-only flag. A write to a read-only line returns `resp_err`=1, changes no data and does not make the line dirty.
- R9: A one-cycle pulse on `inv_all` clears every valid and dirty flag. The next access to any block misses, and discarded dirty data is never written to memory.
- R10: A pulse on `inv_line` clears the valid and dirty flags of the line that holds the block of `inv_addr`, if that block is present. Other lines keep their contents.
- R11: After reset `req_ready`=1, `resp_valid`=0, `mem_req`=0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted on this edge when high |
| resp_valid | output | 1 | Response present this cycle |
| resp_rdata | output | 32 | Read data |
| resp_err | output | 1 | Write refused because the line is read-only |
| inv_all | input | 1 | Invalidate every line |
| inv_line | input | 1 | Invalidate the line that holds `inv_addr` |
| inv_addr | input | 10 | Address for single-line invalidation |
| mem_req | output | 1 | Memory word request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write (write-back), 0 = read (refill) |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | 32 | Refill data, valid with `mem_ack` |
| mem_rdonly | input | 1 | Read-only attribute of the refilled block, valid with `mem_ack` |

## Verification
A sequential sweep over the first 64 words fills every set with four blocks in turn. It separates the first-word miss from the hits on the following words and exercises clean evictions. A directed sequence in one set then separates the recency choice from invalid-first filling and clean victims from dirty ones, and confirms the write-back-before-refill order. The read-only region and both invalidation inputs are driven against lines whose contents the bench knows. A long pseudo-random mix of reads and writes compares every read with a bench-side shadow of the latest written values, so any lost or misplaced write-back appears as wrong data.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 32;
    localparam int NUM_SETS  = 4;
    localparam int BLK_WORDS = 4;
    localparam int OFF_W     = $clog2(BLK_WORDS);
    localparam int IDX_W     = $clog2(NUM_SETS);
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic ro;
        tag_t tag;
    } line_meta_t;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_LOOK,
        CS_EVICT,
        CS_FILL
    } cstate_t;

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic idx_t idx_of(addr_t a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic off_t off_of(addr_t a);
        return a[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/dc_meta.sv
module dc_meta
    import dcache_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  idx_t                 look_idx,
    input  tag_t                 look_tag,
    output logic [1:0]           hit,
    output logic                 hit_ro,
    output logic                 victim,
    output line_meta_t [1:0]     set_lines,
    input  logic                 fill_en,
    input  logic                 fill_way,
    input  logic                 fill_ro,
    input  logic                 dirty_en,
    input  logic                 dirty_way,
    input  logic                 touch_en,
    input  logic                 touch_way,
    input  logic                 inv_all,
    input  logic                 inv_line,
    input  idx_t                 inv_idx,
    input  tag_t                 inv_tag
);

    line_meta_t              tbl [2][NUM_SETS];
    logic [NUM_SETS-1:0]     mru;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < 2; w++)
                for (int s = 0; s < NUM_SETS; s++)
                    tbl[w][s] <= '0;
            mru <= '0;
        end else begin
            if (fill_en)
                tbl[fill_way][look_idx] <= '{valid: 1'b1, dirty: 1'b0, ro: fill_ro, tag: look_tag};
            if (dirty_en)
                tbl[dirty_way][look_idx].dirty <= 1'b1;
            if (touch_en)
                mru[look_idx] <= touch_way;
            for (int w = 0; w < 2; w++) begin
                if (inv_line && tbl[w][inv_idx].valid && tbl[w][inv_idx].tag == inv_tag) begin
                    tbl[w][inv_idx].valid <= 1'b0;
                    tbl[w][inv_idx].dirty <= 1'b0;
                end
            end
            if (inv_all) begin
                for (int w = 0; w < 2; w++)
                    for (int s = 0; s < NUM_SETS; s++) begin
                        tbl[w][s].valid <= 1'b0;
                        tbl[w][s].dirty <= 1'b0;
                    end
            end
        end
    end

    for (genvar w = 0; w < 2; w++) begin : g_way
        assign set_lines[w] = tbl[w][look_idx];
        assign hit[w]       = set_lines[w].valid && (set_lines[w].tag == look_tag);
    end

    assign hit_ro = (hit[0] && set_lines[0].ro) || (hit[1] && set_lines[1].ro);

    always_comb begin
        if (!set_lines[0].valid)      victim = 1'b0;
        else if (!set_lines[1].valid) victim = 1'b1;
        else                          victim = ~mru[look_idx];
    end

    assert_single_hit_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    assert_fill_only_on_miss_R4: assert property (@(posedge clk) disable iff (rst)
        fill_en |-> (hit == 2'b00));

    assert_dirty_writable_hit_R8: assert property (@(posedge clk) disable iff (rst)
        dirty_en |-> (hit[dirty_way] && !set_lines[dirty_way].ro));

endmodule

// File: rtl/dc_data.sv
module dc_data
    import dcache_pkg::*;
(
    input  logic            clk,
    input  idx_t            idx,
    input  off_t            rd_off,
    output word_t [1:0]     rd_word,
    input  logic            we,
    input  logic            we_way,
    input  off_t            we_off,
    input  word_t           wdata
);

    word_t store [2][NUM_SETS][BLK_WORDS];

    always_ff @(posedge clk) begin
        if (we)
            store[we_way][idx][we_off] <= wdata;
    end

    for (genvar w = 0; w < 2; w++) begin : g_rd
        assign rd_word[w] = store[w][idx][rd_off];
    end

endmodule

// File: rtl/dcache2w.sv
module dcache2w
    import dcache_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 resp_valid,
    output logic [DATA_W-1:0]    resp_rdata,
    output logic                 resp_err,
    input  logic                 inv_all,
    input  logic                 inv_line,
    input  logic [ADDR_W-1:0]    inv_addr,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_ack,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_rdonly
);

    cstate_t          st;
    logic             r_write;
    addr_t            r_addr;
    word_t            r_wdata;
    logic             vic_way;
    off_t             beat;

    logic [1:0]       hit;
    logic             hit_ro;
    logic             victim;
    line_meta_t [1:0] set_lines;
    word_t [1:0]      rd_word;

    idx_t  cur_idx;
    tag_t  cur_tag;
    off_t  cur_off;
    logic  any_hit;
    logic  hit_way;
    logic  last_beat;
    logic  wr_hit;
    logic  fill_word;

    assign cur_idx   = idx_of(r_addr);
    assign cur_tag   = tag_of(r_addr);
    assign cur_off   = off_of(r_addr);
    assign any_hit   = |hit;
    assign hit_way   = hit[1];
    assign last_beat = (beat == off_t'(BLK_WORDS - 1));
    assign fill_word = (st == CS_FILL) && mem_ack;

    assign req_ready  = (st == CS_IDLE);
    assign resp_valid = (st == CS_LOOK) && any_hit;
    assign resp_rdata = rd_word[hit_way];
    assign resp_err   = resp_valid && r_write && hit_ro;
    assign wr_hit     = resp_valid && r_write && !hit_ro;

    assign mem_req   = (st == CS_EVICT) || (st == CS_FILL);
    assign mem_we    = (st == CS_EVICT);
    assign mem_addr  = (st == CS_EVICT) ? {set_lines[vic_way].tag, cur_idx, beat}
                                        : {cur_tag, cur_idx, beat};
    assign mem_wdata = rd_word[vic_way];

    dc_meta u_meta (
        .clk       (clk),
        .rst       (rst),
        .look_idx  (cur_idx),
        .look_tag  (cur_tag),
        .hit       (hit),
        .hit_ro    (hit_ro),
        .victim    (victim),
        .set_lines (set_lines),
        .fill_en   (fill_word && last_beat),
        .fill_way  (vic_way),
        .fill_ro   (mem_rdonly),
        .dirty_en  (wr_hit),
        .dirty_way (hit_way),
        .touch_en  (resp_valid),
        .touch_way (hit_way),
        .inv_all   (inv_all),
        .inv_line  (inv_line),
        .inv_idx   (idx_of(inv_addr)),
        .inv_tag   (tag_of(inv_addr))
    );

    dc_data u_data (
        .clk     (clk),
        .idx     (cur_idx),
        .rd_off  ((st == CS_EVICT) ? beat : cur_off),
        .rd_word (rd_word),
        .we      (wr_hit || fill_word),
        .we_way  (fill_word ? vic_way : hit_way),
        .we_off  (fill_word ? beat : cur_off),
        .wdata   (fill_word ? mem_rdata : r_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= CS_IDLE;
            r_write <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
            vic_way <= 1'b0;
            beat    <= '0;
        end else begin
            unique case (st)
                CS_IDLE: if (req_valid) begin
                    r_write <= req_write;
                    r_addr  <= req_addr;
                    r_wdata <= req_wdata;
                    st      <= CS_LOOK;
                end
                CS_LOOK: if (any_hit) begin
                    st <= CS_IDLE;
                end else begin
                    vic_way <= victim;
                    beat    <= '0;
                    st      <= (set_lines[victim].valid && set_lines[victim].dirty) ? CS_EVICT : CS_FILL;
                end
                CS_EVICT: if (mem_ack) begin
                    beat <= beat + 1'b1;
                    if (last_beat) st <= CS_FILL;
                end
                CS_FILL: if (mem_ack) begin
                    beat <= beat + 1'b1;
                    if (last_beat) st <= CS_LOOK;
                end
                default: st <= CS_IDLE;
            endcase
        end
    end

    assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_wb_only_dirty_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (set_lines[vic_way].valid && set_lines[vic_way].dirty));

    assert_no_mem_on_hit_R3: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !mem_req);

endmodule

// File: tb/sim_dcache2w.sv
`timescale 1ns/1ps
module sim_dcache2w;
    import dcache_pkg::*;

    localparam int MEM_LAT = 6;
    localparam int MEM_N   = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready, resp_valid, resp_err;
    logic [DATA_W-1:0] resp_rdata;
    logic              inv_all = 1'b0, inv_line = 1'b0;
    logic [ADDR_W-1:0] inv_addr = '0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ack;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_rdonly;

    dcache2w u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err),
        .inv_all(inv_all), .inv_line(inv_line), .inv_addr(inv_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_rdonly(mem_rdonly)
    );

    function automatic logic [DATA_W-1:0] init_val(int a);
        return (DATA_W'(a) * 32'h0001_0003) ^ 32'h5A5A_0000;
    endfunction

    // memory model: fixed latency per word, addresses at or above 512 are read-only
    logic [DATA_W-1:0] mem_arr [MEM_N];
    int  lat_cnt, rd_cnt, wr_cnt, last_wr_rd;
    always @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < MEM_N; a++) mem_arr[a] <= init_val(a);
            mem_ack <= 1'b0; mem_rdata <= '0; mem_rdonly <= 1'b0;
            lat_cnt <= 0; rd_cnt <= 0; wr_cnt <= 0; last_wr_rd <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; lat_cnt <= 0;
        end else if (mem_req) begin
            if (lat_cnt == MEM_LAT - 1) begin
                mem_ack    <= 1'b1;
                lat_cnt    <= 0;
                mem_rdata  <= mem_arr[mem_addr];
                mem_rdonly <= (mem_addr >= ADDR_W'(512));
                if (mem_we) begin
                    mem_arr[mem_addr] <= mem_wdata;
                    wr_cnt     <= wr_cnt + 1;
                    last_wr_rd <= rd_cnt;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            lat_cnt <= 0;
        end
    end

    int checks = 0, errors = 0;
    logic [DATA_W-1:0] truth [MEM_N];

    task automatic chk(input logic ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    logic [DATA_W-1:0] a_rd;
    logic              a_err;
    int                a_cyc, a_rds, a_wrs;
    logic              a_rdy_ok;

    task automatic access(input logic wr, input int a, input logic [DATA_W-1:0] wd);
        int r0, w0;
        while (!req_ready) @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        a_cyc = 1; a_rdy_ok = 1'b1;
        while (!resp_valid && a_cyc < 5000) begin
            if (req_ready) a_rdy_ok = 1'b0;
            @(negedge clk);
            a_cyc++;
        end
        if (req_ready) a_rdy_ok = 1'b0;
        a_rd = resp_rdata; a_err = resp_err;
        a_rds = rd_cnt - r0; a_wrs = wr_cnt - w0;
        if (wr && !resp_err && resp_valid) truth[a] = wd;
    endtask

    // want: 1 = must hit, 0 = must miss (clean victim), -1 = either
    task automatic rd_chk(input int a, input int want, input string tag);
        access(1'b0, a, '0);
        chk(a_rd == truth[a], {tag, " read data"}, a_rd, truth[a]);
        if (want == 1) begin
            chk(a_cyc == 1 && a_rds == 0, {tag, " expected hit (cycles)"}, a_cyc, 1);
        end else if (want == 0) begin
            chk(a_cyc > 1 && a_rds == BLK_WORDS && a_wrs == 0, {tag, " expected clean miss (refill reads)"}, a_rds, BLK_WORDS);
            chk(a_rdy_ok, {tag, " R2 ready low during miss"}, a_rdy_ok, 1);
        end
    endtask

    task automatic pulse_inv(input logic all, input int a);
        @(negedge clk);
        inv_all = all; inv_line = !all; inv_addr = ADDR_W'(a);
        @(negedge clk);
        inv_all = 1'b0; inv_line = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int a = 0; a < MEM_N; a++) truth[a] = init_val(a);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(req_ready == 1'b1, "R11 ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R11 resp_valid after reset", resp_valid, 0);
        chk(mem_req == 1'b0, "R11 mem_req after reset", mem_req, 0);
        rd_chk(5, 0, "R11 first access misses");

        // R1 R2 R4 sweep: 16 blocks over 4 sets, first word misses, rest hit
        pulse_inv(1'b1, 0);
        for (int a = 0; a < 64; a++)
            rd_chk(a, (a % BLK_WORDS == 0) ? 0 : 1, "R1_R4 sweep");

        // R3 write hit to block 12 (set 0, way 1)
        access(1'b1, 48, 32'hDEAD_0048);
        chk(a_cyc == 1 && a_err == 1'b0, "R3 write hit in one cycle, no error", a_cyc, 1);
        chk(a_rds == 0 && a_wrs == 0, "R3 write hit makes no memory traffic", a_rds + a_wrs, 0);
        chk(mem_arr[48] == init_val(48), "R3 memory untouched by write hit", mem_arr[48], init_val(48));
        rd_chk(48, 1, "R3 read back after write hit");

        // R7 victim is the non-recent way (block 8, clean)
        rd_chk(0, 0, "R7 evict least recent clean block");
        // R5 dirty victim block 12 written back before refill
        access(1'b0, 16, '0);
        chk(a_wrs == BLK_WORDS && a_rds == BLK_WORDS, "R5 write-back then refill counts", a_wrs, BLK_WORDS);
        chk(last_wr_rd == rd_cnt - BLK_WORDS, "R5 write-back precedes refill reads", last_wr_rd, rd_cnt - BLK_WORDS);
        chk(mem_arr[48] == 32'hDEAD_0048, "R5 dirty word reached memory", mem_arr[48], 32'hDEAD_0048);
        chk(a_rd == truth[16], "R5 read data after write-back", a_rd, truth[16]);

        // R7 recency: touch block 0, miss block 8 evicts block 4
        rd_chk(0, 1, "R7 hit block 0");
        rd_chk(32, 0, "R7 refill block 8");
        rd_chk(0, 1, "R7 recent block kept");
        rd_chk(16, 0, "R7 older block evicted");

        // R6 write miss allocates (block 25, set 1)
        access(1'b1, 100, 32'hBEEF_0100);
        chk(a_rds == BLK_WORDS && a_wrs == 0 && a_err == 1'b0, "R6 write miss refills block", a_rds, BLK_WORDS);
        chk(mem_arr[100] == init_val(100), "R6 memory not written by write miss", mem_arr[100], init_val(100));
        rd_chk(100, 1, "R6 written word hits");
        rd_chk(101, 1, "R6 neighbour word hits");

        // R9 global invalidate discards dirty data
        pulse_inv(1'b1, 0);
        for (int a = 0; a < MEM_N; a++) truth[a] = mem_arr[a];
        rd_chk(100, 0, "R9 miss after global invalidate");
        chk(a_rd == init_val(100), "R9 dirty data discarded", a_rd, init_val(100));
        rd_chk(36, 0, "R7 invalid way filled first");
        rd_chk(100, 1, "R7 first block kept");

        // R10 single-line invalidate
        pulse_inv(1'b0, 102);
        rd_chk(36, 1, "R10 other line kept");
        rd_chk(100, 0, "R10 invalidated line misses");
        rd_chk(36, 1, "R10 refill used invalid way");

        // R8 read-only lines
        rd_chk(600, 0, "R8 refill read-only block");
        access(1'b1, 600, 32'h1234_5678);
        chk(a_err == 1'b1 && a_cyc == 1, "R8 write to read-only hit refused", a_err, 1);
        chk(a_rds == 0 && a_wrs == 0, "R8 refused write makes no traffic", a_rds + a_wrs, 0);
        rd_chk(600, 1, "R8 data unchanged after refused write");
        access(1'b1, 700, 32'h8765_4321);
        chk(a_err == 1'b1 && a_rds == BLK_WORDS, "R8 write miss to read-only refused after refill", a_err, 1);
        rd_chk(700, 1, "R8 data unchanged after refused write miss");
        rd_chk(696 + 64, 0, "R8 set 2 fill");
        rd_chk(696 + 128, 0, "R8 read-only line evicted clean");

        // random mix over 256 words, compared with shadow of latest writes
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            int a;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = int'(lf[7:0]);
            if (lf[9:8] == 2'b00) begin
                access(1'b1, a, {lf, ~lf});
                chk(a_err == 1'b0, "R6 random write accepted", a_err, 0);
            end else begin
                rd_chk(a, -1, "R4_R5 random read");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule